// File: doc/BRIEF.md
# Parallel NOR Flash Control-Side Emulator

This block models the control behaviour of a parallel NOR flash part. It is meant to stand in for the device in a system-level bench or an FPGA prototype. It watches the active-low chip enable, output enable, write enable and hardware reset pins, all sampled on a free-running clock. Command decoding is reduced to three single-cycle strobes: enter ID-read, start an embedded operation, and operation finished. From these it tracks the device mode. Its outputs are the ready/busy pin, the data-bus drive enable and a source select. The select tells the surrounding model whether a read returns array data, an ID code or status bits.

The hardware reset pin is qualified by a counter, so a pulse shorter than the minimum width leaves the device untouched. A long enough pulse aborts whatever is running. The recovery that follows depends on whether an embedded operation was active at that moment. If one was, ready/busy stays low for a long recovery period. If none was, a short internal recovery runs and ready/busy stays high. After the pin is released, a further post-reset delay must pass before reads drive the bus again. All delays are parameters in clock cycles. A 3-bit debug output exposes the mode for direct checking.

Top module: `flash_ctl_emu`

## Requirements
- R1: After the system reset `rst_n` is released, the mode is read-array (0), or standby (4) when `ce_n` is high; `ry_by_n` is 1 and `dq_oe` is 0 while `oe_n` is high.
- R2: When `hw_reset_n` is sampled low on T_RP consecutive clock edges, the mode becomes reset (3) at the T_RP-th edge, from any mode, aborting a running operation.
- R3: A `hw_reset_n` low pulse sampled on fewer than T_RP edges leaves the mode unchanged once the pin is high again.
- R4: While `hw_reset_n` is low, for any pulse length, `dq_oe` is 0 and the command strobes have no effect.
- R5: If the reset is committed while the mode is busy (2), `ry_by_n` stays 0 for T_RDY_BUSY clock edges after the commit edge and is 1 from the next edge on.
- R6: If the reset is committed while no operation runs, `ry_by_n` stays 1 and the internal recovery takes T_RDY_IDLE edges.
- R7: After `hw_reset_n` is sampled high, the mode stays reset (3) and `dq_oe` is 0 through the T_RH-th edge (T_RH at least 1). It returns to read-array (0) at the next edge, provided the recovery time has also elapsed.
- R8: With `oe_n` high, `dq_oe` is 0; with `ce_n`, `oe_n` and `hw_reset_n` low/low/high outside reset, `dq_oe` is 1.
- R9: With `ce_n` high, `dq_oe` is 0 whatever `oe_n` is, and the mode reports standby (4) unless busy or in reset.
- R10: In read-array, `cmd_autoselect` with `ce_n` and `we_n` low enters ID-read (1), where `dq_src` is 1 (ID register). A start strobe in ID-read is ignored.
- R11: In read-array, an accepted `cmd_start` enters busy (2) with `ry_by_n` 0 and `dq_src` 2 (status). Raising `ce_n` does not end it; `op_done` returns it to read-array with `ry_by_n` 1.
- R12: A command strobe is accepted only when `ce_n` and `we_n` are both low; `dq_src` is 0 (array) in read-array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low system reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| hw_reset_n | input | 1 | Active-low hardware reset pin |
| cmd_autoselect | input | 1 | Strobe: enter ID-read mode |
| cmd_start | input | 1 | Strobe: start embedded program/erase |
| op_done | input | 1 | Strobe: embedded operation finished |
| ry_by_n | output | 1 | Ready (1) / busy (0) |
| dq_oe | output | 1 | Data bus drive enable |
| dq_src | output | 2 | Read source: 0 array, 1 ID, 2 status |
| mode_dbg | output | 3 | Mode: 0 read, 1 ID-read, 2 busy, 3 reset, 4 standby |

## Verification
The assertions assume that every input is synchronous to `clk` and that each strobe lasts a single cycle. They also assume `op_done` is raised only while an operation is running. The bench changes inputs on the falling edge and samples outputs there, one rising edge after each change. Strobes are cleared on the next vector, and the reset pin is held low for an exact number of sampled edges, so the commit edge and the release edge are known precisely.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_IDREAD  = 3'd1,
        MODE_BUSY    = 3'd2,
        MODE_RESET   = 3'd3,
        MODE_STANDBY = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_ID     = 2'd1,
        SRC_STATUS = 2'd2
    } src_e;

    typedef struct packed {
        mode_e st;
    } fsm_state_t;

endpackage

// File: rtl/flash_rst_qual.sv
module flash_rst_qual #(
    parameter int unsigned T_RP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic commit
);
    localparam int unsigned CW = $clog2(T_RP + 1);
    localparam logic [CW-1:0] LAST = CW'(T_RP - 1);
    localparam logic [CW-1:0] SAT  = CW'(T_RP);

    typedef struct packed {
        logic [CW-1:0] low;
    } qual_t;

    qual_t qual_d, qual_q;

    always_comb begin
        qual_d = qual_q;
        if (pin_n) begin
            qual_d.low = '0;
        end else if (qual_q.low != SAT) begin
            qual_d.low = qual_q.low + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qual_q <= '0;
        else        qual_q <= qual_d;
    end

    // the T_RP-th consecutive low sample commits the reset
    assign commit = !pin_n && (qual_q.low == LAST);

    // R2: one commit per low pulse
    a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/flash_recov_timer.sv
module flash_recov_timer #(
    parameter int unsigned T_RH       = 3,
    parameter int unsigned T_RDY_BUSY = 10,
    parameter int unsigned T_RDY_IDLE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic commit,
    input  logic busy_now,
    input  logic in_reset,
    output logic rdy_done,
    output logic rh_done,
    output logic rec_busy
);
    localparam int unsigned M1   = (T_RDY_BUSY > T_RDY_IDLE) ? T_RDY_BUSY : T_RDY_IDLE;
    localparam int unsigned MAXV = (M1 > T_RH) ? M1 : T_RH;
    localparam int unsigned CW   = $clog2(MAXV + 1);
    localparam logic [CW-1:0] LD_BUSY = CW'(T_RDY_BUSY);
    localparam logic [CW-1:0] LD_IDLE = CW'(T_RDY_IDLE);
    localparam logic [CW-1:0] LD_RH   = CW'(T_RH);

    typedef struct packed {
        logic [CW-1:0] rdy;
        logic [CW-1:0] rh;
        logic          was_busy;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign rec_busy = in_reset && tmr_q.was_busy && (tmr_q.rdy != '0);
    assign rdy_done = (tmr_q.rdy == '0);
    assign rh_done  = (tmr_q.rh == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (commit) begin
            tmr_d.was_busy = busy_now || rec_busy;
            tmr_d.rdy      = (busy_now || rec_busy) ? LD_BUSY : LD_IDLE;
            tmr_d.rh       = LD_RH;
        end else if (in_reset) begin
            if (tmr_q.rdy != '0) tmr_d.rdy = tmr_q.rdy - 1'b1;
            if (!pin_n)                tmr_d.rh = LD_RH;
            else if (tmr_q.rh != '0)   tmr_d.rh = tmr_q.rh - 1'b1;
        end else begin
            tmr_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R5: a reset taken during an operation raises the busy recovery
    a_r5_busy_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && busy_now) |=> rec_busy);

    // R7: read-back delay restarts while the pin is low
    a_r7_rh_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (in_reset && !pin_n) |=> !rh_done);

endmodule

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
    import flash_emu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_n,
    input  logic  ce_n,
    input  logic  we_n,
    input  logic  cmd_autoselect,
    input  logic  cmd_start,
    input  logic  op_done,
    input  logic  commit,
    input  logic  rdy_done,
    input  logic  rh_done,
    output mode_e st
);
    fsm_state_t fsm_d, fsm_q;
    logic       wr_ok;

    // command writes need the pin high and both enables low
    assign wr_ok = pin_n && !ce_n && !we_n;

    always_comb begin
        fsm_d = fsm_q;
        if (commit) begin
            fsm_d.st = MODE_RESET;
        end else begin
            unique case (fsm_q.st)
                MODE_READ: begin
                    if (wr_ok && cmd_autoselect) fsm_d.st = MODE_IDREAD;
                    else if (wr_ok && cmd_start) fsm_d.st = MODE_BUSY;
                end
                MODE_IDREAD: fsm_d.st = MODE_IDREAD;
                MODE_BUSY: begin
                    if (op_done) fsm_d.st = MODE_READ;
                end
                MODE_RESET: begin
                    if (pin_n && rdy_done && rh_done) fsm_d.st = MODE_READ;
                end
                default: fsm_d.st = MODE_READ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: MODE_READ};
        else        fsm_q <= fsm_d;
    end

    assign st = fsm_q.st;

    // R2: commit always lands in reset
    a_r2_commit_enters_reset: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st == MODE_RESET));

    // R7: no exit from reset while the pin is low
    a_r7_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MODE_RESET && !pin_n) |=> (st == MODE_RESET));

    // R11: only completion or a reset ends an operation
    a_r11_busy_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MODE_BUSY && !op_done && !commit) |=> (st == MODE_BUSY));

    // R3: read-array left only by a command or a committed reset
    a_r3_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MODE_READ && !commit && !cmd_autoselect && !cmd_start) |=> (st == MODE_READ));

endmodule

// File: rtl/flash_out_ctl.sv
module flash_out_ctl
    import flash_emu_pkg::*;
(
    input  mode_e       st,
    input  logic        pin_n,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        rec_busy,
    output logic        ry_by_n,
    output logic        dq_oe,
    output logic [1:0]  dq_src,
    output logic [2:0]  mode_dbg
);
    src_e  src;
    mode_e dbg;

    always_comb begin
        unique case (st)
            MODE_IDREAD: src = SRC_ID;
            MODE_BUSY:   src = SRC_STATUS;
            default:     src = SRC_ARRAY;
        endcase
    end

    always_comb begin
        if (st == MODE_RESET || st == MODE_BUSY) dbg = st;
        else if (!pin_n || ce_n)                 dbg = MODE_STANDBY;
        else                                     dbg = st;
    end

    assign ry_by_n  = !((st == MODE_BUSY) || rec_busy);
    assign dq_oe    = pin_n && !ce_n && !oe_n && (st != MODE_RESET);
    assign dq_src   = src;
    assign mode_dbg = dbg;

endmodule

// File: rtl/flash_ctl_emu.sv
module flash_ctl_emu
    import flash_emu_pkg::*;
#(
    parameter int unsigned T_RP       = 4,
    parameter int unsigned T_RH       = 3,
    parameter int unsigned T_RDY_BUSY = 10,
    parameter int unsigned T_RDY_IDLE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic       hw_reset_n,
    input  logic       cmd_autoselect,
    input  logic       cmd_start,
    input  logic       op_done,
    output logic       ry_by_n,
    output logic       dq_oe,
    output logic [1:0] dq_src,
    output logic [2:0] mode_dbg
);
    logic  commit, rdy_done, rh_done, rec_busy;
    mode_e st;

    flash_rst_qual #(.T_RP(T_RP)) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (hw_reset_n),
        .commit (commit)
    );

    flash_recov_timer #(
        .T_RH       (T_RH),
        .T_RDY_BUSY (T_RDY_BUSY),
        .T_RDY_IDLE (T_RDY_IDLE)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (hw_reset_n),
        .commit   (commit),
        .busy_now (st == MODE_BUSY),
        .in_reset (st == MODE_RESET),
        .rdy_done (rdy_done),
        .rh_done  (rh_done),
        .rec_busy (rec_busy)
    );

    flash_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .pin_n          (hw_reset_n),
        .ce_n           (ce_n),
        .we_n           (we_n),
        .cmd_autoselect (cmd_autoselect),
        .cmd_start      (cmd_start),
        .op_done        (op_done),
        .commit         (commit),
        .rdy_done       (rdy_done),
        .rh_done        (rh_done),
        .st             (st)
    );

    flash_out_ctl u_out (
        .st       (st),
        .pin_n    (hw_reset_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .rec_busy (rec_busy),
        .ry_by_n  (ry_by_n),
        .dq_oe    (dq_oe),
        .dq_src   (dq_src),
        .mode_dbg (mode_dbg)
    );

    // R4: the bus is never driven while the reset pin is low
    a_r4_no_drive_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_reset_n) |-> !dq_oe);

    // R5: busy recovery keeps the pin low
    a_r5_recovery_busy_pin: assert property (@(posedge clk) disable iff (!rst_n)
        rec_busy |-> !ry_by_n);

endmodule

// File: tb/tb_flash_ctl_emu.sv
`timescale 1ns/1ps
module tb_flash_ctl_emu;

    localparam int unsigned P_RP  = 4;
    localparam int unsigned P_RH  = 3;
    localparam int unsigned P_RDB = 10;
    localparam int unsigned P_RDI = 2;

    logic clk = 1'b0;
    logic rst_n, ce_n, oe_n, we_n, hw_reset_n;
    logic cmd_autoselect, cmd_start, op_done;
    logic ry_by_n, dq_oe;
    logic [1:0] dq_src;
    logic [2:0] mode_dbg;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    flash_ctl_emu #(
        .T_RP(P_RP), .T_RH(P_RH), .T_RDY_BUSY(P_RDB), .T_RDY_IDLE(P_RDI)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hw_reset_n(hw_reset_n), .cmd_autoselect(cmd_autoselect),
        .cmd_start(cmd_start), .op_done(op_done), .ry_by_n(ry_by_n),
        .dq_oe(dq_oe), .dq_src(dq_src), .mode_dbg(mode_dbg)
    );

    typedef struct packed {
        logic       ce_n;
        logic       oe_n;
        logic       we_n;
        logic       as;
        logic       st;
        logic [2:0] mode;
        logic       ry;
        logic       oe;
        logic [1:0] src;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b1,1'b0,1'b0,3'd4,1'b1,1'b0,2'd0,4'd9},   // R9 idle deselected
        '{1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,1'b1,1'b1,2'd0,4'd8},   // R8 array read drives
        '{1'b0,1'b1,1'b1,1'b0,1'b0,3'd0,1'b1,1'b0,2'd0,4'd8},   // R8 oe high
        '{1'b1,1'b1,1'b0,1'b1,1'b0,3'd4,1'b1,1'b0,2'd0,4'd12},  // R12 ce high blocks
        '{1'b0,1'b1,1'b0,1'b1,1'b0,3'd1,1'b1,1'b0,2'd1,4'd10},  // R10 enter ID read
        '{1'b0,1'b0,1'b1,1'b0,1'b0,3'd1,1'b1,1'b1,2'd1,4'd10},  // R10 ID source
        '{1'b0,1'b1,1'b0,1'b0,1'b1,3'd1,1'b1,1'b0,2'd1,4'd10},  // R10 start ignored
        '{1'b1,1'b0,1'b1,1'b0,1'b0,3'd4,1'b1,1'b0,2'd1,4'd9}    // R9 standby with oe low
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pins(input logic c, input logic o, input logic w);
        ce_n = c; oe_n = o; we_n = w;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        summary();
    end

    initial begin
        rst_n = 1'b0; hw_reset_n = 1'b1;
        pins(1'b1, 1'b1, 1'b1);
        cmd_autoselect = 1'b0; cmd_start = 1'b0; op_done = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 mode", int'(mode_dbg), 4);
        chk("R1 ry_by_n", int'(ry_by_n), 1);
        chk("R1 dq_oe", int'(dq_oe), 0);

        for (int i = 0; i < NV; i++) begin
            pins(VECS[i].ce_n, VECS[i].oe_n, VECS[i].we_n);
            cmd_autoselect = VECS[i].as;
            cmd_start      = VECS[i].st;
            tick(1);
            chk($sformatf("R%0d vec%0d mode", VECS[i].req, i), int'(mode_dbg), int'(VECS[i].mode));
            chk($sformatf("R%0d vec%0d ry", VECS[i].req, i), int'(ry_by_n), int'(VECS[i].ry));
            chk($sformatf("R%0d vec%0d oe", VECS[i].req, i), int'(dq_oe), int'(VECS[i].oe));
            chk($sformatf("R%0d vec%0d src", VECS[i].req, i), int'(dq_src), int'(VECS[i].src));
        end
        cmd_autoselect = 1'b0; cmd_start = 1'b0;

        // R3 / R4: short pulse in ID read
        pins(1'b0, 1'b0, 1'b1);
        hw_reset_n = 1'b0;
        chk("R4 oe during short pulse", int'(dq_oe), 0);
        tick(P_RP - 1);
        chk("R4 oe still low pin", int'(dq_oe), 0);
        hw_reset_n = 1'b1;
        tick(1);
        chk("R3 mode kept", int'(mode_dbg), 1);
        chk("R3 oe back", int'(dq_oe), 1);

        // R2 / R6 / R7: full reset while idle
        hw_reset_n = 1'b0;
        tick(P_RP - 1);
        chk("R2 before commit", int'(mode_dbg), 4);
        tick(1);
        chk("R2 commit", int'(mode_dbg), 3);
        chk("R6 ry stays high", int'(ry_by_n), 1);
        tick(P_RDI);
        chk("R6 ry high after idle recovery", int'(ry_by_n), 1);
        hw_reset_n = 1'b1;
        tick(P_RH);
        chk("R7 still reset", int'(mode_dbg), 3);
        chk("R7 no drive", int'(dq_oe), 0);
        tick(1);
        chk("R7 back to read", int'(mode_dbg), 0);
        chk("R7 drive resumes", int'(dq_oe), 1);

        // R4: commands during a low pin are dropped
        pins(1'b0, 1'b1, 1'b0);
        cmd_start = 1'b1;
        hw_reset_n = 1'b0;
        tick(2);
        chk("R4 start ignored", int'(ry_by_n), 1);
        cmd_start = 1'b0;
        hw_reset_n = 1'b1;
        pins(1'b0, 1'b1, 1'b1);
        tick(1);
        chk("R4 mode read", int'(mode_dbg), 0);

        // R12: start with we_n high ignored, R11 busy path
        cmd_start = 1'b1;
        tick(1);
        chk("R12 we high", int'(mode_dbg), 0);
        pins(1'b0, 1'b1, 1'b0);
        tick(1);
        cmd_start = 1'b0;
        pins(1'b1, 1'b0, 1'b1);
        chk("R11 busy mode", int'(mode_dbg), 2);
        chk("R11 ry low", int'(ry_by_n), 0);
        tick(5);
        chk("R11 deselect keeps busy", int'(mode_dbg), 2);
        pins(1'b0, 1'b0, 1'b1);
        tick(1);
        chk("R11 status src", int'(dq_src), 2);
        chk("R11 status drive", int'(dq_oe), 1);
        op_done = 1'b1;
        tick(1);
        op_done = 1'b0;
        chk("R11 done read", int'(mode_dbg), 0);
        chk("R11 ry high", int'(ry_by_n), 1);
        chk("R12 array src", int'(dq_src), 0);

        // R5: reset during an operation
        pins(1'b0, 1'b1, 1'b0);
        cmd_start = 1'b1;
        tick(1);
        cmd_start = 1'b0;
        pins(1'b0, 1'b1, 1'b1);
        hw_reset_n = 1'b0;
        tick(P_RP - 1);
        chk("R2 busy before commit", int'(mode_dbg), 2);
        tick(1);
        chk("R2 busy aborted", int'(mode_dbg), 3);
        chk("R5 ry low at commit", int'(ry_by_n), 0);
        hw_reset_n = 1'b1;
        tick(P_RDB - 1);
        chk("R5 ry low late", int'(ry_by_n), 0);
        tick(1);
        chk("R5 ry released", int'(ry_by_n), 1);
        chk("R5 still reset", int'(mode_dbg), 3);
        tick(1);
        chk("R5 read after recovery", int'(mode_dbg), 0);

        summary();
    end

endmodule